// File: doc/BRIEF.md
# Scanline Table-Driven Eight-Channel DMA

This block feeds small per-scanline bursts from tables in memory to fixed destination ports. Eight channels share one memory request/acknowledge port. Each channel has a table base address, an 8-bit bank, a direct or indirect addressing choice, and a burst length selector. Software picks the channels that take part through an 8-bit enable mask. A frame strobe arms the channels, and a scanline strobe runs one line of work.

Each table entry begins with a packed counter byte. Bit 7 is a repeat flag and bits 6..0 are a line count. An entry is followed either by inline data bytes (direct mode) or by a two-byte pointer to the data (indirect mode). On every scanline the controller first moves the bursts of all channels that have a transfer armed. Only after that does it walk the channels again, count them down and fetch new entries.

When an operation completes, the block reports the master-cycle overhead it would cost. It also reports an interrupt-check deferral count and per-channel "interrupted" flags, and it keeps a busy flag for the whole time it is working.

Top module: `scan_dma`

## Requirements
- R1: On a frame strobe every channel clears its finished and transfer-armed state. With an all-zero enable mask nothing else happens: no memory access, the reported overhead is 0 and the deferral count is 0.
- R2: On a frame strobe with a nonzero mask, all eight channels become transfer-armed. Each enabled channel, in ascending order, copies its base into its table address and reads its counter byte there. In indirect mode it then reads a pointer low byte and then a pointer high byte. The table address advances by one per byte read.
- R3: The overhead reported for a frame with a nonzero mask is 18. For a scanline it is 8 if any enabled channel is unfinished, plus 8 per enabled unfinished channel, plus 16 per indirect entry reload. It is 0 when no channel is active.
- R4: An enabled, unfinished, armed channel moves 1, 2 or 4 bytes for burst selector 0, 1, or 2/3. Each byte is read from the table address (direct mode) or from the pointer (indirect mode), and that address then advances. The byte is written to {8'h00, 8'h21, 3'b000, channel[2:0], lane[1:0]}.
- R5: Within a scanline, all burst traffic of all channels, in ascending channel order, comes before any counter update or table fetch. The updates also run in ascending channel order.
- R6: In the update pass each enabled, unfinished channel decrements its counter byte and takes the new bit 7 as its armed state. If bits 6..0 are then zero, it reads the next counter byte from the table address, advances that address, and becomes armed.
- R7: An indirect reload then reads the pointer low byte and then the high byte. If the newly loaded counter byte is zero, it reads only one byte, which becomes the high byte, and the low byte is forced to 0.
- R8: A reloaded counter byte of zero finishes the channel for the rest of the frame: it does no transfers, no updates and no overhead. The next frame strobe restarts it if it is still enabled.
- R9: A scanline with a nonzero mask ORs the mask into the interrupted flags, which a frame strobe clears. It also reports a deferral count of 2. A scanline with a zero mask does nothing and reports 0.
- R10: Every table and data read uses {bank, 16-bit address}. The 16-bit address wraps from FFFF to 0000 without carrying into the bank. A request holds its address, direction and data until it is acknowledged.
- R11: Busy is high from the cycle after a strobe is accepted until the completion pulse. A strobe that arrives while busy is held and served afterwards, frame before scanline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_mask | input | 8 | Channel enable mask, bit n for channel n |
| cfg_base | input | 128 | Table base per channel, 16 bits each, channel 0 lowest |
| cfg_bank | input | 64 | Bank per channel, 8 bits each |
| cfg_ind | input | 8 | Indirect addressing select per channel |
| cfg_mode | input | 16 | Burst length selector per channel, 2 bits each |
| frame_go | input | 1 | Frame-start strobe |
| line_go | input | 1 | Scanline-start strobe |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Memory address {bank, address} |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Memory acknowledge; completes the request this cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| ovh_cycles | output | 12 | Overhead of the last operation, in master cycles |
| irq_defer | output | 2 | Interrupt-check deferral count of the last operation |
| intr_flags | output | 8 | Per-channel interrupted flags |

## Verification
The assertions assume that the memory never acknowledges a request the block is not making. They also assume that the enable mask and the channel configuration stay stable while busy is high. The bench's memory model answers only pending requests, with a one-cycle registered acknowledge. The bench changes the mask and configuration only between the completion pulse and the next strobe. For a held strobe it changes nothing until both completion pulses have been seen.

// File: rtl/scan_dma_pkg.sv
package scan_dma_pkg;
  localparam int TW  = 16;  // table address width
  localparam int BKW = 8;   // bank width

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_RD, S_WR, S_NEXT, S_DONE} state_t;
  typedef enum logic [1:0] {P_INIT, P_XFER, P_UPD} phase_t;
  typedef enum logic [2:0] {K_CNT, K_LO, K_HI, K_HIZ, K_DATA} kind_t;

  function automatic logic [2:0] burst_len(input logic [1:0] sel);
    case (sel)
      2'd0:    burst_len = 3'd1;
      2'd1:    burst_len = 3'd2;
      default: burst_len = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/scan_dma_chan.sv
module scan_dma_chan
  import scan_dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_clr,
  input  logic          frame_arm,
  input  logic          ld_base,
  input  logic [TW-1:0] base,
  input  logic          inc_taddr,
  input  logic          ld_cnt,
  input  logic [7:0]    cnt_d,
  input  logic          ld_ind_lo,
  input  logic          ld_ind_hi,
  input  logic          zero_lo,
  input  logic          inc_ind,
  input  logic [7:0]    byte_d,
  input  logic          ld_pend,
  input  logic          pend_d,
  input  logic          set_fin,
  output logic [TW-1:0] taddr,
  output logic [7:0]    cnt,
  output logic [TW-1:0] ind,
  output logic          pend,
  output logic          fin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      taddr <= '0;
      cnt   <= '0;
      ind   <= '0;
      pend  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      if (frame_clr) begin
        fin  <= 1'b0;
        pend <= 1'b0;
      end
      if (frame_arm) pend <= 1'b1;
      if (ld_pend)   pend <= pend_d;
      if (set_fin)   fin  <= 1'b1;
      if (ld_base)        taddr <= base;
      else if (inc_taddr) taddr <= taddr + 1'b1;
      if (ld_cnt) cnt <= cnt_d;
      if (ld_ind_lo)      ind <= {ind[TW-1:8], byte_d};
      else if (ld_ind_hi) ind <= {byte_d, zero_lo ? 8'h00 : ind[7:0]};
      else if (inc_ind)   ind <= ind + 1'b1;
    end
  end

  // R8: a finished channel always holds a zero counter byte
  p_fin_cnt_zero_r8: assert property (@(posedge clk) disable iff (rst)
    fin |-> (cnt == 8'h00));
endmodule

// File: rtl/scan_dma_cost.sv
module scan_dma_cost #(
  parameter int OW     = 12,
  parameter int INIT_C = 18,
  parameter int LINE_C = 8,
  parameter int CH_C   = 8,
  parameter int IND_C  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add_init,
  input  logic          add_line,
  input  logic          add_ch,
  input  logic          add_ind,
  output logic [OW-1:0] acc
);
  logic [OW-1:0] inc;
  always_comb begin
    inc = '0;
    if (add_init) inc = inc + OW'(INIT_C);
    if (add_line) inc = inc + OW'(LINE_C);
    if (add_ch)   inc = inc + OW'(CH_C);
    if (add_ind)  inc = inc + OW'(IND_C);
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= (clr ? '0 : acc) + inc;
  end
endmodule

// File: rtl/scan_dma.sv
module scan_dma
  import scan_dma_pkg::*;
#(
  parameter int          NCH      = 8,
  parameter int          OW       = 12,
  parameter int          INIT_C   = 18,
  parameter int          LINE_C   = 8,
  parameter int          CH_C     = 8,
  parameter int          IND_C    = 16,
  parameter logic [7:0]  DST_BANK = 8'h00,
  parameter logic [7:0]  DST_PAGE = 8'h21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH-1:0]     en_mask,
  input  logic [NCH*TW-1:0]  cfg_base,
  input  logic [NCH*BKW-1:0] cfg_bank,
  input  logic [NCH-1:0]     cfg_ind,
  input  logic [NCH*2-1:0]   cfg_mode,
  input  logic               frame_go,
  input  logic               line_go,
  output logic               mem_req,
  output logic               mem_we,
  output logic [23:0]        mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic               mem_ack,
  input  logic [7:0]         mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [OW-1:0]      ovh_cycles,
  output logic [1:0]         irq_defer,
  output logic [NCH-1:0]     intr_flags
);
  localparam int CW = $clog2(NCH);

  state_t         state;
  phase_t         phase;
  kind_t          kind;
  logic [CW-1:0]  ch;
  logic [2:0]     nleft;
  logic [1:0]     lane;
  logic [7:0]     data_q;
  logic [NCH-1:0] mask_q;
  logic [1:0]     defer_q;
  logic           pend_frame, pend_line;

  logic [TW-1:0] taddr_a [NCH];
  logic [TW-1:0] ind_a   [NCH];
  logic [7:0]    cnt_a   [NCH];
  logic [NCH-1:0] pend_v, fin_v;

  // command decode for the selected channel
  logic c_clr, c_arm, c_ld_base, c_inc_taddr, c_ld_cnt, c_ld_lo, c_ld_hi;
  logic c_zlo, c_inc_ind, c_ld_pend, c_pend_d, c_set_fin;
  logic [7:0] c_cnt_d;
  logic cost_clr, add_init, add_line, add_ch, add_ind;
  logic [OW-1:0] cost_acc;

  logic            go_frame, go_line, act;
  logic [TW-1:0]   cur_base, cur_taddr, cur_ind, ptr;
  logic [BKW-1:0]  cur_bank;
  logic [1:0]      cur_mode;
  logic            cur_indm;
  logic [7:0]      cur_cnt, newc;

  assign go_frame  = frame_go | pend_frame;
  assign go_line   = line_go  | pend_line;
  assign cur_base  = cfg_base[int'(ch)*TW +: TW];
  assign cur_bank  = cfg_bank[int'(ch)*BKW +: BKW];
  assign cur_mode  = cfg_mode[int'(ch)*2 +: 2];
  assign cur_indm  = cfg_ind[ch];
  assign cur_taddr = taddr_a[ch];
  assign cur_ind   = ind_a[ch];
  assign cur_cnt   = cnt_a[ch];
  assign newc      = cur_cnt - 8'd1;
  assign act       = mask_q[ch] & ~fin_v[ch];
  assign busy      = (state != S_IDLE);

  always_comb begin
    {c_clr, c_arm, c_ld_base, c_inc_taddr, c_ld_cnt, c_ld_lo, c_ld_hi} = '0;
    {c_zlo, c_inc_ind, c_ld_pend, c_pend_d, c_set_fin} = '0;
    c_cnt_d = mem_rdata;
    {cost_clr, add_init, add_line, add_ch, add_ind} = '0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = data_q;
    ptr       = (kind == K_DATA && cur_indm) ? cur_ind : cur_taddr;
    mem_addr  = {cur_bank, ptr};
    case (state)
      S_IDLE: begin
        if (go_frame) begin
          c_clr = 1'b1;  c_arm = |en_mask;
          cost_clr = 1'b1;  add_init = |en_mask;
        end else if (go_line) begin
          cost_clr = 1'b1;  add_line = |(en_mask & ~fin_v);
        end
      end
      S_SCAN: begin
        case (phase)
          P_INIT:  c_ld_base = mask_q[ch];
          P_XFER:  add_ch = act;
          default: if (act) begin
            c_ld_cnt = 1'b1;  c_cnt_d = newc;
            c_ld_pend = 1'b1; c_pend_d = newc[7];
          end
        endcase
      end
      S_RD: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          case (kind)
            K_CNT: begin
              c_ld_cnt = 1'b1;  c_inc_taddr = 1'b1;
              if (phase == P_UPD) begin
                c_ld_pend = 1'b1;  c_pend_d = 1'b1;
                c_set_fin = (mem_rdata == 8'h00);
                add_ind   = cur_indm;
              end
            end
            K_LO:  begin c_ld_lo = 1'b1; c_inc_taddr = 1'b1; end
            K_HI:  begin c_ld_hi = 1'b1; c_inc_taddr = 1'b1; end
            K_HIZ: begin c_ld_hi = 1'b1; c_zlo = 1'b1; c_inc_taddr = 1'b1; end
            default: begin
              c_inc_ind   = cur_indm;
              c_inc_taddr = ~cur_indm;
            end
          endcase
        end
      end
      S_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {DST_BANK, DST_PAGE, 8'({ch, lane})};
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic sel;
    assign sel = (ch == CW'(i));
    scan_dma_chan u_chan (
      .clk(clk), .rst(rst),
      .frame_clr(c_clr), .frame_arm(c_arm),
      .ld_base(c_ld_base & sel), .base(cfg_base[i*TW +: TW]),
      .inc_taddr(c_inc_taddr & sel),
      .ld_cnt(c_ld_cnt & sel), .cnt_d(c_cnt_d),
      .ld_ind_lo(c_ld_lo & sel), .ld_ind_hi(c_ld_hi & sel), .zero_lo(c_zlo),
      .inc_ind(c_inc_ind & sel), .byte_d(mem_rdata),
      .ld_pend(c_ld_pend & sel), .pend_d(c_pend_d),
      .set_fin(c_set_fin & sel),
      .taddr(taddr_a[i]), .cnt(cnt_a[i]), .ind(ind_a[i]),
      .pend(pend_v[i]), .fin(fin_v[i])
    );
  end

  scan_dma_cost #(.OW(OW), .INIT_C(INIT_C), .LINE_C(LINE_C), .CH_C(CH_C),
                  .IND_C(IND_C)) u_cost (
    .clk(clk), .rst(rst), .clr(cost_clr), .add_init(add_init),
    .add_line(add_line), .add_ch(add_ch), .add_ind(add_ind), .acc(cost_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;  phase <= P_INIT;  kind <= K_CNT;
      ch <= '0;  nleft <= '0;  lane <= '0;  data_q <= '0;
      mask_q <= '0;  defer_q <= '0;  pend_frame <= 1'b0;  pend_line <= 1'b0;
      done <= 1'b0;  ovh_cycles <= '0;  irq_defer <= '0;  intr_flags <= '0;
    end else begin
      done       <= 1'b0;
      pend_frame <= pend_frame | frame_go;
      pend_line  <= pend_line  | line_go;
      case (state)
        S_IDLE: begin
          ch <= '0;
          if (go_frame) begin
            pend_frame <= 1'b0;
            mask_q     <= en_mask;
            intr_flags <= '0;
            defer_q    <= 2'd0;
            phase      <= P_INIT;
            state      <= (|en_mask) ? S_SCAN : S_DONE;
          end else if (go_line) begin
            pend_line  <= line_go & 1'b0;
            mask_q     <= en_mask;
            intr_flags <= intr_flags | en_mask;
            defer_q    <= (|en_mask) ? 2'd2 : 2'd0;
            phase      <= P_XFER;
            state      <= (|en_mask) ? S_SCAN : S_DONE;
          end
        end
        S_SCAN: begin
          kind  <= K_CNT;
          state <= S_NEXT;
          case (phase)
            P_INIT: if (mask_q[ch]) state <= S_RD;
            P_XFER: if (act && pend_v[ch]) begin
              kind  <= K_DATA;
              nleft <= burst_len(cur_mode);
              lane  <= '0;
              state <= S_RD;
            end
            default: if (act && newc[6:0] == 7'd0) state <= S_RD;
          endcase
        end
        S_RD: if (mem_ack) begin
          case (kind)
            K_CNT: begin
              if (cur_indm)
                kind <= (phase == P_UPD && mem_rdata == 8'h00) ? K_HIZ : K_LO;
              else
                state <= S_NEXT;
            end
            K_LO:   kind  <= K_HI;
            K_DATA: begin data_q <= mem_rdata; state <= S_WR; end
            default: state <= S_NEXT;
          endcase
        end
        S_WR: if (mem_ack) begin
          if (nleft == 3'd1) state <= S_NEXT;
          else begin
            nleft <= nleft - 3'd1;
            lane  <= lane + 2'd1;
            kind  <= K_DATA;
            state <= S_RD;
          end
        end
        S_NEXT: begin
          if (ch == CW'(NCH - 1)) begin
            ch <= '0;
            if (phase == P_XFER) begin phase <= P_UPD; state <= S_SCAN; end
            else state <= S_DONE;
          end else begin
            ch    <= ch + 1'b1;
            state <= S_SCAN;
          end
        end
        default: begin
          done       <= 1'b1;
          ovh_cycles <= cost_acc;
          irq_defer  <= defer_q;
          state      <= S_IDLE;
        end
      endcase
    end
  end

  // R1: no memory traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
  // R5: destination writes occur only in the burst pass
  p_write_in_burst_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (phase == P_XFER));
  // R10: a pending request is held until acknowledged
  p_req_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata)));
  // R9: deferral count is either 0 or 2
  p_defer_value_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (irq_defer == 2'd0 || irq_defer == 2'd2));
  // R11: completion pulse coincides with return to idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R11: scanline strobe seen while busy is retained
  p_line_held_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && line_go) |=> pend_line);
endmodule

// File: tb/scan_dma_bench.sv
`timescale 1ns/1ps
module scan_dma_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [7:0]   en_mask;
  logic [127:0] cfg_base;
  logic [63:0]  cfg_bank;
  logic [7:0]   cfg_ind;
  logic [15:0]  cfg_mode;
  logic frame_go, line_go, mem_req, mem_we, mem_ack, busy, done;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, intr_flags;
  logic [11:0] ovh_cycles;
  logic [1:0]  irq_defer;

  logic [15:0] c_base [8];
  logic [7:0]  c_bank [8];
  logic        c_ind  [8];
  logic [1:0]  c_mode [8];
  int unsigned seed;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      cfg_base[i*16 +: 16] = c_base[i];
      cfg_bank[i*8 +: 8]   = c_bank[i];
      cfg_ind[i]           = c_ind[i];
      cfg_mode[i*2 +: 2]   = c_mode[i];
    end
  end

  scan_dma u_scan_dma (
    .clk(clk), .rst(rst), .en_mask(en_mask), .cfg_base(cfg_base),
    .cfg_bank(cfg_bank), .cfg_ind(cfg_ind), .cfg_mode(cfg_mode),
    .frame_go(frame_go), .line_go(line_go), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .ovh_cycles(ovh_cycles), .irq_defer(irq_defer), .intr_flags(intr_flags)
  );

  // memory contents computed from the address: counts 0..3, optional repeat bit
  function automatic logic [7:0] memf(input logic [23:0] a, input int unsigned s);
    logic [31:0] v;
    v = ({8'h00, a} ^ ({8'h00, a} >> 5)) * 32'd73 + s;
    return {v[4], 5'b00000, v[1:0]};
  endfunction
  assign mem_rdata = memf(mem_addr, seed);

  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else     mem_ack <= mem_req && !mem_ack;
  end

  // observed transaction log
  logic        lg_we   [256];
  logic [23:0] lg_addr [256];
  logic [7:0]  lg_data [256];
  int lg_n;
  always @(negedge clk) begin
    if (mem_req && mem_ack && lg_n < 256) begin
      lg_we[lg_n]   = mem_we;
      lg_addr[lg_n] = mem_addr;
      lg_data[lg_n] = mem_we ? mem_wdata : mem_rdata;
      lg_n = lg_n + 1;
    end
  end

  // expected model, written from the requirements
  logic        ex_we   [256];
  logic [23:0] ex_addr [256];
  logic [7:0]  ex_data [256];
  int ex_n;
  logic [15:0] m_taddr [8];
  logic [15:0] m_ind   [8];
  logic [7:0]  m_cnt   [8];
  logic        m_pend  [8];
  logic        m_fin   [8];
  logic [7:0]  m_intr;
  int          m_ovh;
  int          m_defer;

  int total = 0;
  int fails = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ex_push(input logic we, input logic [23:0] a, input logic [7:0] d);
    if (ex_n < 256) begin
      ex_we[ex_n] = we; ex_addr[ex_n] = a; ex_data[ex_n] = d;
    end
    ex_n++;
  endtask

  task automatic m_read(input int ch, input logic [15:0] a, output logic [7:0] d);
    d = memf({c_bank[ch], a}, seed);
    ex_push(1'b0, {c_bank[ch], a}, d);
  endtask

  task automatic m_frame(input logic [7:0] mask);
    logic [7:0] lo, hi;
    ex_n = 0; m_ovh = 0; m_defer = 0; m_intr = 8'h00;
    for (int i = 0; i < 8; i++) begin m_fin[i] = 1'b0; m_pend[i] = 1'b0; end
    if (mask != 8'h00) begin
      m_ovh = 18;
      for (int i = 0; i < 8; i++) m_pend[i] = 1'b1;
      for (int i = 0; i < 8; i++) if (mask[i]) begin
        m_taddr[i] = c_base[i];
        m_read(i, m_taddr[i], m_cnt[i]); m_taddr[i]++;
        if (c_ind[i]) begin
          m_read(i, m_taddr[i], lo); m_taddr[i]++;
          m_read(i, m_taddr[i], hi); m_taddr[i]++;
          m_ind[i] = {hi, lo};
        end
      end
    end
  endtask

  task automatic m_line(input logic [7:0] mask, input bit fresh);
    logic [7:0] d, lo, hi;
    int n;
    bit any;
    if (fresh) ex_n = 0;
    m_ovh = 0; m_defer = 0;
    if (mask == 8'h00) return;
    m_defer = 2;
    m_intr  = m_intr | mask;
    any = 1'b0;
    for (int i = 0; i < 8; i++) if (mask[i] && !m_fin[i]) any = 1'b1;
    if (any) m_ovh = 8;
    for (int i = 0; i < 8; i++) if (mask[i] && !m_fin[i]) begin
      m_ovh += 8;
      if (m_pend[i]) begin
        n = (c_mode[i] == 2'd0) ? 1 : (c_mode[i] == 2'd1) ? 2 : 4;
        for (int k = 0; k < n; k++) begin
          if (c_ind[i]) begin m_read(i, m_ind[i], d); m_ind[i]++; end
          else          begin m_read(i, m_taddr[i], d); m_taddr[i]++; end
          ex_push(1'b1, {8'h00, 8'h21, 3'b000, 3'(i), 2'(k)}, d);
        end
      end
    end
    for (int i = 0; i < 8; i++) if (mask[i] && !m_fin[i]) begin
      m_cnt[i]  = m_cnt[i] - 8'd1;
      m_pend[i] = m_cnt[i][7];
      if (m_cnt[i][6:0] == 7'd0) begin
        m_read(i, m_taddr[i], m_cnt[i]); m_taddr[i]++;
        if (c_ind[i]) begin
          m_ovh += 16;
          if (m_cnt[i] == 8'h00) begin
            m_read(i, m_taddr[i], hi); m_taddr[i]++;
            m_ind[i] = {hi, 8'h00};
          end else begin
            m_read(i, m_taddr[i], lo); m_taddr[i]++;
            m_read(i, m_taddr[i], hi); m_taddr[i]++;
            m_ind[i] = {hi, lo};
          end
        end
        if (m_cnt[i] == 8'h00) m_fin[i] = 1'b1;
        m_pend[i] = 1'b1;
      end
    end
  endtask

  task automatic cmp_log(input string tag);
    int bad;
    bad = -1;
    total++;
    if (lg_n != ex_n) begin
      fails++;
      $display("FAIL %s length: actual %0d expected %0d", tag, lg_n, ex_n);
      return;
    end
    for (int i = 0; i < ex_n && i < 256; i++)
      if (bad < 0 && (lg_we[i] != ex_we[i] || lg_addr[i] != ex_addr[i] ||
                      lg_data[i] != ex_data[i])) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s entry %0d: actual we=%0d addr=%06h data=%02h expected we=%0d addr=%06h data=%02h",
               tag, bad, lg_we[bad], lg_addr[bad], lg_data[bad],
               ex_we[bad], ex_addr[bad], ex_data[bad]);
    end
  endtask

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    @(negedge clk);
    while (!done && t < 4000) begin @(negedge clk); t++; end
    if (!done) chk({tag, " R11 completion timeout"}, 0, 1);
  endtask

  task automatic pulse(input bit frame);
    @(negedge clk);
    if (frame) frame_go = 1'b1; else line_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0; line_go = 1'b0;
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " R3 overhead"}, ovh_cycles, m_ovh);
    chk({tag, " R9 deferral"}, irq_defer, m_defer);
    chk({tag, " R9 interrupted flags"}, intr_flags, m_intr);
  endtask

  task automatic do_frame(input logic [7:0] mask);
    en_mask = mask;
    m_frame(mask);
    lg_n = 0;
    pulse(1'b1);
    chk("R11 busy after frame strobe", busy, 1);
    wait_done("frame");
    cmp_log("R1 R2 R10 frame init traffic");
    check_outs("frame");
  endtask

  task automatic do_line(input logic [7:0] mask);
    en_mask = mask;
    m_line(mask, 1'b1);
    lg_n = 0;
    pulse(1'b0);
    wait_done("line");
    cmp_log("R4 R5 R6 R7 R8 R10 scanline traffic");
    check_outs("line");
  endtask

  task automatic set_cfg(input int s);
    seed = s * 977 + 13;
    for (int i = 0; i < 8; i++) begin
      c_base[i] = 16'h0100 * i[15:0] + 16'(s * 40);
      c_bank[i] = 8'(i & 3) + 8'(s & 1) * 8'h10;
      c_ind[i]  = ((i + s) % 3) == 0;
      c_mode[i] = 2'((i + s) % 4);
    end
    c_base[7] = 16'hFFFE;  // wraps within bank (R10)
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] masks [4];
    masks[0] = 8'hFF; masks[1] = 8'hA5; masks[2] = 8'h5A; masks[3] = 8'h81;
    frame_go = 1'b0; line_go = 1'b0; en_mask = 8'h00; lg_n = 0;
    set_cfg(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R1 reset mem_req", mem_req, 0);
    chk("R11 reset done", done, 0);
    chk("R3 reset overhead", ovh_cycles, 0);
    chk("R9 reset flags", intr_flags, 0);

    // R1: empty mask frame does nothing
    do_frame(8'h00);
    // R9: empty mask scanline does nothing
    do_line(8'h00);

    // sweep of configurations and masks; frames restart finished channels (R8)
    for (int s = 0; s < 8; s++) begin
      set_cfg(s);
      do_frame(masks[s % 4]);
      for (int l = 0; l < 10; l++) do_line(masks[s % 4]);
      do_frame(masks[(s + 1) % 4]);
      for (int l = 0; l < 4; l++) do_line(masks[(s + 1) % 4]);
    end

    // R11: a scanline strobe during a busy scanline is held and served after
    set_cfg(2);
    do_frame(8'hFF);
    en_mask = 8'hFF;
    m_line(8'hFF, 1'b1);
    m_line(8'hFF, 1'b0);
    lg_n = 0;
    pulse(1'b0);
    @(negedge clk);
    chk("R11 busy while first scanline runs", busy, 1);
    pulse(1'b0);
    wait_done("held first");
    wait_done("held second");
    cmp_log("R11 R5 two scanlines back to back");
    check_outs("R11 held line");

    // R11: frame strobe during a scanline is served next
    en_mask = 8'h0F;
    m_line(8'h0F, 1'b1);
    lg_n = 0;
    pulse(1'b0);
    pulse(1'b1);
    wait_done("line before frame");
    cmp_log("R11 scanline before held frame");
    m_frame(8'h0F);
    lg_n = 0;
    wait_done("held frame");
    cmp_log("R11 R2 held frame init");
    check_outs("R11 held frame");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule